// File: doc/BRIEF.md
# Timer Time-Base Unit

This block is the counting core of a general-purpose timer. A prescaler divides the input clock by a programmable factor, and each prescaler tick steps a main counter. The counter wraps at a programmable reload limit and signals an update event each time it wraps. It has three counting modes: rising, falling and centre-aligned. In centre-aligned mode the counter climbs to the limit and falls back to zero, and it signals an update at both turning points. The rate of update events is the input clock divided by (divider + 1) and then by (limit + 1) in the two single-direction modes.

The divider and limit values are written into holding registers. The divider holding value reaches the active divider only on an update event. The limit holding value does the same when limit buffering is enabled; with buffering off, a limit write takes effect on the next clock. A one-cycle force strobe produces an update on demand: it copies both holding values into the active registers and restarts the prescaler and the counter. The update is seen at the outputs as a one-cycle pulse and as a sticky flag that software clears.

The counting direction is kept by a two-state machine. ST_RISE means counting up and ST_FALL means counting down. In centre-aligned mode, ST_RISE moves to ST_FALL on the tick that finds the counter at or above the limit, and ST_FALL moves to ST_RISE on the tick that finds it at zero. Rising mode holds the machine in ST_RISE and falling mode holds it in ST_FALL. A forced update enters ST_FALL in falling mode and ST_RISE in the other modes.

Top module: `tbase_core`

## Requirements
- R1: After reset, the counter value is 0, the direction output is 0, and the update pulse and the update flag are both 0.
- R2: With run enabled, the counter steps once every (divider + 1) clocks. A divider of 0 steps it on every clock.
- R3: In rising mode (mode_sel 2'b00), the counter steps 0, 1, …, limit. The step after the limit returns it to 0 and is an update event. The direction output is 0.
- R4: In falling mode (mode_sel 2'b01), the counter steps limit, limit−1, …, 0. The step after 0 reloads the limit and is an update event. The direction output is 1.
- R5: In centre-aligned mode (mode_sel 2'b10 or 2'b11), the counter rises 0 … limit and then falls limit−1 … 0, and this repeats. The step leaving the limit and the step leaving 0 are both update events. The direction output is 1 while falling.
- R6: While run_en is 0 and no force strobe is present, the counter holds its value and no update occurs.
- R7: With lim_buf_en at 1, a limit write leaves the active limit unchanged until the next update event.
- R8: With lim_buf_en at 0, a limit write becomes the active limit on the next clock.
- R9: A divider write takes effect only at the next update event. The running period completes at the old rate.
- R10: A one-cycle force strobe makes an update event. It loads both holding values and clears the prescaler count. It sets the counter to 0 (rising or centre-aligned mode) or to the new limit (falling mode).
- R11: upd_pulse is high for exactly one cycle per update event. That cycle is the first one in which the counter shows its post-update value.
- R12: upd_flag is set by every update event and stays set until flag_clr is applied. If an update and flag_clr coincide, the flag is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| run_en | input | 1 | Counter enable |
| mode_sel | input | 2 | 00 rising, 01 falling, 1x centre-aligned |
| lim_buf_en | input | 1 | Buffer limit writes until the next update |
| div_wr | input | 1 | Divider write strobe |
| div_wdata | input | 16 | Divider value to write |
| lim_wr | input | 1 | Limit write strobe |
| lim_wdata | input | 16 | Limit value to write |
| force_upd | input | 1 | One-cycle forced update strobe |
| flag_clr | input | 1 | Clear the update flag |
| cnt_val | output | 16 | Current counter value |
| cnt_down | output | 1 | 1 while the counter is falling |
| upd_pulse | output | 1 | One-cycle update indication |
| upd_flag | output | 1 | Sticky update flag |

## Verification
The bench sweeps every mode code, including both centre-aligned codes, over dividers 0 to 2 and small limits, including a limit of 0 in the single-direction modes. For each combination it predicts the counter value, the direction and the pulse cycle by cycle from the tick count. The divider sweep separates a wrong tick spacing from a wrong wrap point. The centre-aligned runs show whether updates fall on both turns or only on one, and whether the turn happens at the limit or one step after it. Directed sequences write the limit and the divider in the middle of a period and apply a force in the middle of a count. They show whether new values are applied too early or too late and whether the prescaler phase is restarted. Further sequences cover the hold when disabled and the ordering of flag clear against flag set.

// File: rtl/tbase_pkg.sv
package tbase_pkg;

    typedef enum logic [1:0] {
        CM_UP      = 2'b00,
        CM_DOWN    = 2'b01,
        CM_CTR     = 2'b10,
        CM_CTR_ALT = 2'b11
    } cnt_mode_e;

    typedef enum logic {
        ST_RISE = 1'b0,
        ST_FALL = 1'b1
    } dir_state_e;

    function automatic logic is_center(input cnt_mode_e m);
        return m[1];
    endfunction

endpackage

// File: rtl/tbase_presc.sv
module tbase_presc #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run_en,
    input  logic         force_upd,
    input  logic         upd_evt,
    input  logic         div_wr,
    input  logic [W-1:0] div_wdata,
    output logic         tick
);
    logic [W-1:0] div_hold;
    logic [W-1:0] div_act;
    logic [W-1:0] div_cnt;

    assign tick = run_en && !force_upd && (div_cnt >= div_act);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_hold <= '0;
            div_act  <= '0;
            div_cnt  <= '0;
        end else begin
            if (div_wr)  div_hold <= div_wdata;
            if (upd_evt) div_act  <= div_hold;
            if (force_upd)   div_cnt <= '0;
            else if (tick)   div_cnt <= '0;
            else if (run_en) div_cnt <= div_cnt + W'(1);
        end
    end

    AST_DIV_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !upd_evt |=> $stable(div_act)); // R9

    AST_DIV_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        force_upd |=> (div_cnt == '0)); // R10

endmodule

// File: rtl/tbase_shadow.sv
module tbase_shadow #(
    parameter int           W    = 16,
    parameter logic [W-1:0] INIT = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         buf_en,
    input  logic         wr,
    input  logic [W-1:0] wdata,
    input  logic         load,
    output logic [W-1:0] hold_val,
    output logic [W-1:0] act_val
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_val <= INIT;
            act_val  <= INIT;
        end else begin
            if (wr) hold_val <= wdata;
            if (wr && !buf_en) act_val <= wdata;
            else if (load)     act_val <= hold_val;
        end
    end

    AST_LIM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (buf_en && !load) |=> $stable(act_val)); // R7

    AST_LIM_DIRECT: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && !buf_en) |=> (act_val == $past(wdata))); // R8

endmodule

// File: rtl/tbase_count.sv
module tbase_count
    import tbase_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic         force_upd,
    input  cnt_mode_e    mode,
    input  logic [W-1:0] lim_act,
    input  logic [W-1:0] lim_hold,
    output logic [W-1:0] cnt,
    output logic         cnt_down,
    output logic         wrap
);
    dir_state_e   state, state_nx;
    logic [W-1:0] cnt_nx;
    logic         ctr;

    assign ctr = is_center(mode);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_RISE;
            cnt   <= '0;
        end else begin
            state <= state_nx;
            cnt   <= cnt_nx;
        end
    end

    // next state, next count and wrap detection
    always_comb begin
        state_nx = state;
        cnt_nx   = cnt;
        wrap     = 1'b0;
        if (force_upd) begin
            state_nx = (mode == CM_DOWN) ? ST_FALL : ST_RISE;
            cnt_nx   = (mode == CM_DOWN) ? lim_hold : '0;
        end else if (!ctr) begin
            state_nx = (mode == CM_DOWN) ? ST_FALL : ST_RISE;
            if (tick) begin
                if (mode == CM_DOWN) begin
                    if (cnt == '0) begin
                        wrap   = 1'b1;
                        cnt_nx = lim_hold;
                    end else begin
                        cnt_nx = cnt - W'(1);
                    end
                end else begin
                    if (cnt >= lim_act) begin
                        wrap   = 1'b1;
                        cnt_nx = '0;
                    end else begin
                        cnt_nx = cnt + W'(1);
                    end
                end
            end
        end else if (tick) begin
            unique case (state)
                ST_RISE: begin
                    if (cnt >= lim_act) begin
                        wrap     = 1'b1;
                        state_nx = ST_FALL;
                        cnt_nx   = (cnt == '0) ? '0 : cnt - W'(1);
                    end else begin
                        cnt_nx = cnt + W'(1);
                    end
                end
                ST_FALL: begin
                    if (cnt == '0) begin
                        wrap     = 1'b1;
                        state_nx = ST_RISE;
                        cnt_nx   = (lim_act == '0) ? '0 : W'(1);
                    end else begin
                        cnt_nx = cnt - W'(1);
                    end
                end
            endcase
        end
    end

    // outputs
    always_comb begin
        cnt_down = (state == ST_FALL);
    end

    AST_FORCE_UP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (force_upd && mode == CM_UP) |=> (cnt == '0)); // R10

    AST_CTR_TURN_TOP: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !force_upd && ctr && state == ST_RISE && cnt >= lim_act) |=> cnt_down); // R5

    AST_CTR_TURN_BOT: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !force_upd && ctr && state == ST_FALL && cnt == '0) |=> !cnt_down); // R5

endmodule

// File: rtl/tbase_core.sv
module tbase_core
    import tbase_pkg::*;
#(
    parameter int           W        = 16,
    parameter logic [W-1:0] LIM_INIT = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run_en,
    input  logic [1:0]   mode_sel,
    input  logic         lim_buf_en,
    input  logic         div_wr,
    input  logic [W-1:0] div_wdata,
    input  logic         lim_wr,
    input  logic [W-1:0] lim_wdata,
    input  logic         force_upd,
    input  logic         flag_clr,
    output logic [W-1:0] cnt_val,
    output logic         cnt_down,
    output logic         upd_pulse,
    output logic         upd_flag
);
    cnt_mode_e    mode;
    logic         tick;
    logic         wrap;
    logic         upd_evt;
    logic [W-1:0] lim_hold;
    logic [W-1:0] lim_act;

    assign mode    = cnt_mode_e'(mode_sel);
    assign upd_evt = wrap || force_upd;

    tbase_presc #(.W(W)) u_presc (
        .clk       (clk),
        .rst_n     (rst_n),
        .run_en    (run_en),
        .force_upd (force_upd),
        .upd_evt   (upd_evt),
        .div_wr    (div_wr),
        .div_wdata (div_wdata),
        .tick      (tick)
    );

    tbase_shadow #(.W(W), .INIT(LIM_INIT)) u_lim (
        .clk      (clk),
        .rst_n    (rst_n),
        .buf_en   (lim_buf_en),
        .wr       (lim_wr),
        .wdata    (lim_wdata),
        .load     (upd_evt),
        .hold_val (lim_hold),
        .act_val  (lim_act)
    );

    tbase_count #(.W(W)) u_count (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .force_upd (force_upd),
        .mode      (mode),
        .lim_act   (lim_act),
        .lim_hold  (lim_hold),
        .cnt       (cnt_val),
        .cnt_down  (cnt_down),
        .wrap      (wrap)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            upd_pulse <= 1'b0;
            upd_flag  <= 1'b0;
        end else begin
            upd_pulse <= upd_evt;
            if (upd_evt)       upd_flag <= 1'b1;
            else if (flag_clr) upd_flag <= 1'b0;
        end
    end

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_flag && !flag_clr) |=> upd_flag); // R12

    AST_FLAG_WITH_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        upd_pulse |-> upd_flag); // R12

    AST_HALT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_en && !force_upd) |=> ($stable(cnt_val) && !upd_pulse)); // R6

    AST_UP_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_pulse && $past(mode_sel) == 2'b00) |-> (cnt_val == '0)); // R3

    AST_DOWN_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_pulse && $past(mode_sel) == 2'b01 && !$past(lim_wr)) |-> (cnt_val == lim_act)); // R4

endmodule

// File: tb/sim_tbase_core.sv
`timescale 1ns/1ps
module sim_tbase_core;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        run_en = 1'b0;
    logic [1:0]  mode_sel = 2'b00;
    logic        lim_buf_en = 1'b1;
    logic        div_wr = 1'b0;
    logic [15:0] div_wdata = '0;
    logic        lim_wr = 1'b0;
    logic [15:0] lim_wdata = '0;
    logic        force_upd = 1'b0;
    logic        flag_clr = 1'b0;
    logic [15:0] cnt_val;
    logic        cnt_down;
    logic        upd_pulse;
    logic        upd_flag;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    tbase_core u0 (
        .clk(clk), .rst_n(rst_n), .run_en(run_en), .mode_sel(mode_sel),
        .lim_buf_en(lim_buf_en), .div_wr(div_wr), .div_wdata(div_wdata),
        .lim_wr(lim_wr), .lim_wdata(lim_wdata), .force_upd(force_upd),
        .flag_clr(flag_clr), .cnt_val(cnt_val), .cnt_down(cnt_down),
        .upd_pulse(upd_pulse), .upd_flag(upd_flag)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic start(input int m, input int p, input int a);
        mode_sel = 2'(m);
        div_wr = 1'b1; div_wdata = 16'(p);
        lim_wr = 1'b1; lim_wdata = 16'(a);
        step();
        div_wr = 1'b0; lim_wr = 1'b0;
        force_upd = 1'b1; run_en = 1'b1;
        step();
        force_upd = 1'b0;
    endtask

    // predicted counter, direction and pulse after j clocks from a forced update
    task automatic sweep(input int m, input int p, input int a);
        int ncyc;
        ncyc = 2 * (p + 1) * (2 * a + 2) + 2;
        start(m, p, a);
        for (int j = 0; j <= ncyc; j++) begin
            int n, ec, ed, ep, pp, per;
            bit tk;
            n  = j / (p + 1);
            tk = (j > 0) && (j % (p + 1) == 0);
            if (m == 0) begin
                ec = n % (a + 1); ed = 0;
                ep = (j == 0 || (tk && ec == 0)) ? 1 : 0;
                chk($sformatf("R3 R2 cnt m%0d p%0d a%0d j%0d", m, p, a, j), cnt_val, ec);
            end else if (m == 1) begin
                ec = a - (n % (a + 1)); ed = 1;
                ep = (j == 0 || (tk && (n % (a + 1)) == 0)) ? 1 : 0;
                chk($sformatf("R4 R2 cnt m%0d p%0d a%0d j%0d", m, p, a, j), cnt_val, ec);
            end else begin
                per = 2 * a;
                pp  = n % per;
                ec  = (pp <= a) ? pp : per - pp;
                ed  = ((pp > a) || (pp == 0 && n > 0)) ? 1 : 0;
                ep  = (j == 0 || (tk && n >= a + 1 &&
                       (pp == 1 || pp == (a + 1) % per))) ? 1 : 0;
                chk($sformatf("R5 R2 cnt m%0d p%0d a%0d j%0d", m, p, a, j), cnt_val, ec);
            end
            chk($sformatf("R5 R3 R4 dir m%0d p%0d a%0d j%0d", m, p, a, j), int'(cnt_down), ed);
            chk($sformatf("R11 R10 pulse m%0d p%0d a%0d j%0d", m, p, a, j), int'(upd_pulse), ep);
            step();
        end
    endtask

    task automatic report();
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            report();
            $finish;
        end
    end

    initial begin
        repeat (3) step();
        rst_n = 1'b1;
        step();
        step();
        // R1 reset state
        chk("R1 cnt", cnt_val, 0);
        chk("R1 dir", int'(cnt_down), 0);
        chk("R1 pulse", int'(upd_pulse), 0);
        chk("R1 flag", int'(upd_flag), 0);

        // R2..R5, R10, R11 sweeps
        for (int m = 0; m < 4; m++) begin
            for (int p = 0; p < 3; p++) begin
                if (m < 2) sweep(m, p, 0);
                sweep(m, p, 1);
                sweep(m, p, 2);
                sweep(m, p, 4);
            end
        end

        // R6 hold while disabled
        lim_buf_en = 1'b1;
        start(0, 0, 9);
        repeat (3) step();
        chk("R6 pre-hold cnt", cnt_val, 3);
        run_en = 1'b0;
        for (int k = 0; k < 5; k++) begin
            step();
            chk("R6 hold cnt", cnt_val, 3);
            chk("R6 hold pulse", int'(upd_pulse), 0);
        end

        // R7 buffered limit write mid-period
        start(0, 0, 3);
        lim_wr = 1'b1; lim_wdata = 16'd6;
        step();
        lim_wr = 1'b0;
        step(); step();
        chk("R7 old limit j3", cnt_val, 3);
        step();
        chk("R7 wrap at old j4 cnt", cnt_val, 0);
        chk("R7 wrap at old j4 pulse", int'(upd_pulse), 1);
        repeat (6) step();
        chk("R7 new limit j10", cnt_val, 6);
        chk("R7 no pulse j10", int'(upd_pulse), 0);
        step();
        chk("R7 wrap new j11 cnt", cnt_val, 0);
        chk("R7 wrap new j11 pulse", int'(upd_pulse), 1);

        // R8 unbuffered limit write
        lim_buf_en = 1'b0;
        start(0, 0, 5);
        lim_wr = 1'b1; lim_wdata = 16'd2;
        step();
        lim_wr = 1'b0;
        chk("R8 j1 cnt", cnt_val, 1);
        step();
        chk("R8 j2 cnt", cnt_val, 2);
        step();
        chk("R8 early wrap cnt", cnt_val, 0);
        chk("R8 early wrap pulse", int'(upd_pulse), 1);
        lim_buf_en = 1'b1;

        // R9 divider write waits for update
        start(0, 0, 3);
        div_wr = 1'b1; div_wdata = 16'd2;
        step();
        div_wr = 1'b0;
        step();
        chk("R9 old rate j2", cnt_val, 2);
        repeat (4) step();
        chk("R9 new rate j6", cnt_val, 0);
        step();
        chk("R9 new rate j7", cnt_val, 1);

        // R10 force mid-count restarts prescaler and counter
        start(0, 1, 9);
        repeat (7) step();
        chk("R10 before force", cnt_val, 3);
        force_upd = 1'b1;
        step();
        force_upd = 1'b0;
        chk("R10 force cnt", cnt_val, 0);
        chk("R10 force pulse", int'(upd_pulse), 1);
        step();
        chk("R10 self clear pulse", int'(upd_pulse), 0);
        chk("R10 presc restart j1", cnt_val, 0);
        step();
        chk("R10 presc restart j2", cnt_val, 1);
        start(1, 0, 7);
        chk("R10 down force cnt", cnt_val, 7);

        // R12 sticky flag
        run_en = 1'b0;
        flag_clr = 1'b1;
        step();
        flag_clr = 1'b0;
        chk("R12 cleared", int'(upd_flag), 0);
        step();
        chk("R12 stays clear", int'(upd_flag), 0);
        start(0, 0, 1);
        run_en = 1'b0;
        chk("R12 set", int'(upd_flag), 1);
        repeat (4) step();
        chk("R12 sticky pulse", int'(upd_pulse), 0);
        chk("R12 sticky flag", int'(upd_flag), 1);
        flag_clr = 1'b1; force_upd = 1'b1;
        step();
        flag_clr = 1'b0; force_upd = 1'b0;
        chk("R12 set wins", int'(upd_flag), 1);

        done = 1'b1;
        report();
        $finish;
    end
endmodule